// File: doc/BRIEF.md
# Ping-Pong Audio Playback Engine

This block plays audio out of a circular sample buffer held in system memory. Software programs a base address, a buffer length and a sample format through a small 32-bit register port, then sets the run bit. The engine fetches 32-bit little-endian words one at a time and unpacks them into samples. It widens 8-bit samples and duplicates mono samples, so that every item on its output stream is a stereo pair of 16-bit values, handed over with a valid/ready handshake.

The buffer is treated as two equal halves. When the engine finishes the first half it sets a half-done flag. When it finishes the second half it sets a wrap flag and starts again at the base address. Either flag can raise the interrupt line, so software can refill one half while the other plays. A separate bit-clock enable pulse, derived from the system clock, gives the codec side its pacing.

Top module: `pingpong_playback`

## Requirements
- R1: After reset the mode (0x00), interrupt status (0x20) and interrupt enable (0x24) registers read 0, `irq` is low, `mem_req` is low and `smp_valid` is low.
- R2: Writing value v to the threshold register (0x2C) makes the buffer (v+1)*4 bytes long. Each half is (v+1)*2 bytes. Consuming the byte that reaches the half point sets status bit 6. Consuming the last byte sets status bit 7 and restarts reading at the base address.
- R3: Reading the position register (0x38) returns the current half start divided by 4: 0 in the first half, (v+1)/2 in the second half (integer division).
- R4: A write to the status register clears exactly the bits written as 1 and leaves the other bits unchanged.
- R5: `irq` is high exactly when the status register ANDed with the enable register is nonzero. It follows enable writes and status clears in the next cycle.
- R6: A 0-to-1 write of mode bit 7 (run) clears the status and the play position. A write to the clock divider (0x18), the base low half (0x28, bits 15:0) or the base high half (0x40, bits 15:0) returns the position to the base without clearing status.
- R7: With mode bit 0 set (16-bit) and bit 14 clear (stereo), each word gives one pair: left is bits 15:0, right is bits 31:16.
- R8: With mode bit 0 set and bit 14 set (mono), each halfword in ascending order gives one pair with left equal to right.
- R9: With mode bit 0 clear (8-bit) and stereo, bytes are taken in ascending address order, alternately left then right. Each byte is multiplied by 256 (placed in bits 15:8, low byte 0).
- R10: With 8-bit mono, each byte in ascending order is multiplied by 256 and driven on both channels.
- R11: While `smp_valid` is high and `smp_ready` is low, `smp_valid`, `smp_left` and `smp_right` hold, and playback does not advance.
- R12: `bclk_en` pulses for one cycle every REF*(div[15:8]+1) cycles. REF is HI_REF_CYC when mode bit 9 is set and LO_REF_CYC otherwise.
- R13: At most one memory read is outstanding. `mem_req` and `mem_addr` hold until `mem_rvalid`. Every address is word-aligned and lies inside [base, base+length).
- R14: While mode bit 7 is clear, no new memory request is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory read request, held until response |
| mem_addr | output | 32 | Word-aligned read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data, little-endian |
| smp_valid | output | 1 | Stereo pair available |
| smp_ready | input | 1 | Consumer accepts the pair |
| smp_left | output | 16 | Left sample |
| smp_right | output | 16 | Right sample |
| irq | output | 1 | Interrupt request |
| bclk_en | output | 1 | Single-cycle bit-clock enable |

## Verification
The checker watches four properties on every cycle:
- output hold under back-pressure;
- request stability until the response;
- the absence of requests while stopped;
- the status wipe after a run-bit rising edge.

It also checks that bit-clock pulses are isolated when the reference ratios exceed one. The value-level behaviour can only be shown by bench scenarios, which compare each accepted pair against a software model of memory. That behaviour covers the unpacking order of each format, widening, wrap at the buffer end, and the cycle at which the half and wrap flags appear relative to consumed samples. Bench scenarios also cover the position readback, write-one-to-clear, and the exact bit-clock spacing.

// File: rtl/pingpong_playback.sv
module pingpong_playback #(
  parameter int TW         = 16,
  parameter int LO_REF_CYC = 6,
  parameter int HI_REF_CYC = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        smp_valid,
  input  logic        smp_ready,
  output logic [15:0] smp_left,
  output logic [15:0] smp_right,
  output logic        irq,
  output logic        bclk_en
);
  localparam int LW     = TW + 3;
  localparam int MAXREF = (LO_REF_CYC > HI_REF_CYC) ? LO_REF_CYC : HI_REF_CYC;
  localparam int CW     = $clog2(MAXREF * 256 + 1) + 1;
  localparam logic [7:0] A_MODE = 8'h00, A_DIV = 8'h18, A_STAT = 8'h20, A_IEN = 8'h24,
                         A_BLO  = 8'h28, A_THR = 8'h2C, A_POS  = 8'h38, A_BHI = 8'h40;

  logic [31:0]   mode_r, div_r, ien_r, base_r, wd;
  logic [TW-1:0] thr_r;
  logic [1:0]    st_r;
  logic [LW-1:0] ptr;
  logic          second, have_l, wv, stale;
  logic [15:0]   lft;
  logic [CW-1:0] bcnt;

  wire wr_mode = reg_we && reg_addr == A_MODE;
  wire wr_div  = reg_we && reg_addr == A_DIV;
  wire wr_stat = reg_we && reg_addr == A_STAT;
  wire wr_ien  = reg_we && reg_addr == A_IEN;
  wire wr_blo  = reg_we && reg_addr == A_BLO;
  wire wr_thr  = reg_we && reg_addr == A_THR;
  wire wr_bhi  = reg_we && reg_addr == A_BHI;

  wire rearm = wr_mode && reg_wdata[7] && !mode_r[7];
  wire repos = rearm || wr_div || wr_blo || wr_bhi;
  wire s16   = mode_r[0];
  wire mono  = mode_r[14];

  wire [LW-1:0] buf_len  = (LW'(thr_r) + LW'(1)) << 2;
  wire [LW-1:0] half_len = buf_len >> 1;
  wire [LW-1:0] ptr_nx   = ptr + (s16 ? LW'(2) : LW'(1));
  wire [LW-1:0] pos      = second ? half_len : '0;

  wire take     = mode_r[7] && wv && (!smp_valid || smp_ready) && !repos;
  wire hit_half = take && !second && ptr_nx >= half_len;
  wire hit_end  = take && ptr_nx >= buf_len;

  wire [4:0]  bsel = {ptr[1:0], 3'b000};
  wire [15:0] elem = s16 ? (ptr[1] ? wd[31:16] : wd[15:0]) : {wd[bsel +: 8], 8'h00};

  wire [CW-1:0] bper = CW'(mode_r[9] ? HI_REF_CYC : LO_REF_CYC) * (CW'(div_r[15:8]) + CW'(1));

  assign irq = |(st_r & ien_r[7:6]);

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = mode_r;
      A_DIV:   reg_rdata = div_r;
      A_STAT:  reg_rdata = {24'h0, st_r, 6'h0};
      A_IEN:   reg_rdata = ien_r;
      A_POS:   reg_rdata = 32'(pos >> 2);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_r <= '0;
      div_r  <= '0;
      ien_r  <= '0;
      base_r <= '0;
      thr_r  <= '0;
      st_r   <= '0;
    end else begin
      if (wr_mode) mode_r <= reg_wdata;
      if (wr_div)  div_r  <= reg_wdata;
      if (wr_ien)  ien_r  <= reg_wdata;
      if (wr_thr)  thr_r  <= reg_wdata[TW-1:0];
      if (wr_blo)  base_r[15:0]  <= reg_wdata[15:0];
      if (wr_bhi)  base_r[31:16] <= reg_wdata[15:0];
      if (rearm) st_r <= '0;
      else       st_r <= (st_r & ~(wr_stat ? reg_wdata[7:6] : 2'b00)) | {hit_end, hit_half};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      wd        <= '0;
      wv        <= 1'b0;
      stale     <= 1'b0;
      ptr       <= '0;
      second    <= 1'b0;
      have_l    <= 1'b0;
      lft       <= '0;
      smp_valid <= 1'b0;
      smp_left  <= '0;
      smp_right <= '0;
    end else begin
      if (mem_rvalid) mem_req <= 1'b0;
      else if (mode_r[7] && !wv && !mem_req && !repos) begin
        mem_req  <= 1'b1;
        mem_addr <= base_r + 32'({ptr[LW-1:2], 2'b00});
      end
      if (smp_valid && smp_ready) smp_valid <= 1'b0;
      if (repos) begin
        ptr    <= '0;
        second <= 1'b0;
        have_l <= 1'b0;
        wv     <= 1'b0;
        stale  <= mem_req && !mem_rvalid;
      end else begin
        if (mem_rvalid) begin
          stale <= 1'b0;
          if (!stale) begin
            wv <= 1'b1;
            wd <= mem_rdata;
          end
        end
        if (take) begin
          ptr <= hit_end ? '0 : ptr_nx;
          if (hit_half) second <= 1'b1;
          if (hit_end)  second <= 1'b0;
          if (ptr_nx[1:0] == 2'b00 || hit_end) wv <= 1'b0;
          if (mono) begin
            smp_valid <= 1'b1;
            smp_left  <= elem;
            smp_right <= elem;
          end else if (!have_l) begin
            lft    <= elem;
            have_l <= 1'b1;
          end else begin
            smp_valid <= 1'b1;
            smp_left  <= lft;
            smp_right <= elem;
            have_l    <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt    <= '0;
      bclk_en <= 1'b0;
    end else if (bcnt >= bper - CW'(1)) begin
      bcnt    <= '0;
      bclk_en <= 1'b1;
    end else begin
      bcnt    <= bcnt + CW'(1);
      bclk_en <= 1'b0;
    end
  end
endmodule

// File: rtl/pingpong_playback_chk.sv
module pingpong_playback_chk #(
  parameter int LO_REF_CYC = 6,
  parameter int HI_REF_CYC = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [7:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] mode_r,
  input logic [1:0]  st_r,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_rvalid,
  input logic        smp_valid,
  input logic        smp_ready,
  input logic [15:0] smp_left,
  input logic [15:0] smp_right,
  input logic        bclk_en
);
  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !smp_ready |=> smp_valid && $stable(smp_left) && $stable(smp_right));

  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

  // R14
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_r[7] && !mem_req |=> !mem_req);

  // R6
  rearm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 8'h00 && reg_wdata[7] && !mode_r[7] |=> st_r == 2'b00);

  generate
    if (LO_REF_CYC > 1 && HI_REF_CYC > 1) begin : g_bclk
      // R12
      bclk_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_en |=> !bclk_en);
    end
  endgenerate
endmodule

bind pingpong_playback pingpong_playback_chk #(
  .LO_REF_CYC(LO_REF_CYC),
  .HI_REF_CYC(HI_REF_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .mode_r(mode_r), .st_r(st_r), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_rvalid(mem_rvalid), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .smp_left(smp_left), .smp_right(smp_right), .bclk_en(bclk_en)
);

// File: tb/sim_pingpong_playback.sv
`timescale 1ns/1ps
module sim_pingpong_playback;
  localparam int LO = 6;
  localparam int HI = 3;

  logic        clk = 0, rst_n = 0, reg_we = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, mem_rdata = 0;
  logic        mem_rvalid = 0, smp_ready = 0;
  wire  [31:0] reg_rdata, mem_addr;
  wire         mem_req, smp_valid, irq, bclk_en;
  wire  [15:0] smp_left, smp_right;

  int n_run = 0, n_fail = 0;
  logic [31:0] cur_base = 0, cur_len = 4;
  bit addr_bad = 0, pend = 0;
  int lat = 0;

  always #2.5 clk = ~clk;

  pingpong_playback #(.TW(16), .LO_REF_CYC(LO), .HI_REF_CYC(HI)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_left(smp_left), .smp_right(smp_right), .irq(irq), .bclk_en(bclk_en));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mword(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'hA5C30F1E;
  endfunction

  function automatic logic [15:0] elem_at(input logic [31:0] base, input bit s16, input int off);
    logic [31:0] w;
    w = mword(base + 32'(off & ~3)) >> (8 * (off & 3));
    return s16 ? w[15:0] : {w[7:0], 8'h00};
  endfunction

  task automatic exp_frame(input logic [31:0] base, input bit s16, input bit mono, input int len,
                           input int k, output logic [15:0] l, output logic [15:0] r);
    int esz = s16 ? 2 : 1;
    if (mono) begin
      l = elem_at(base, s16, (k * esz) % len);
      r = l;
    end else begin
      l = elem_at(base, s16, (2 * k * esz) % len);
      r = elem_at(base, s16, ((2 * k + 1) * esz) % len);
    end
  endtask

  always @(negedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req && !pend) begin
      pend = 1;
      lat = $urandom_range(0, 2);
      if (mem_addr[1:0] != 2'b00 || mem_addr < cur_base || mem_addr >= cur_base + cur_len)
        addr_bad = 1;
    end else if (pend) begin
      if (lat == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mword(mem_addr);
        pend = 0;
      end else lat--;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #0.1 v = reg_rdata;
  endtask

  task automatic start(input logic [31:0] base, input int thr, input logic [31:0] mode);
    wr(8'h00, 0);
    cur_base = base; cur_len = 32'((thr + 1) * 4); addr_bad = 0;
    wr(8'h28, {16'h0, base[15:0]});
    wr(8'h40, {16'h0, base[31:16]});
    wr(8'h2C, 32'(thr));
    wr(8'h00, mode);
  endtask

  task automatic drain();
    wr(8'h00, 0);
    smp_ready = 1;
    repeat (6) @(negedge clk);
    smp_ready = 0;
  endtask

  task automatic run_stream(input int n, input logic [31:0] base, input bit s16, input bit mono,
                            input int len, input bit skip, input string tag);
    int k = 0, cyc = 0;
    bit sk = skip;
    logic [15:0] el, er;
    while (k < n && cyc < n * 60) begin
      @(negedge clk);
      cyc++;
      smp_ready = ($urandom % 4) != 0;
      if (smp_valid && smp_ready) begin
        if (sk) sk = 0;
        else begin
          exp_frame(base, s16, mono, len, k, el, er);
          chk({smp_left, smp_right} == {el, er}, tag, {smp_left, smp_right}, {el, er});
          k++;
        end
      end
    end
    chk(k == n, "R2 stream progress", 32'(k), 32'(n));
    @(negedge clk);
    smp_ready = 0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) begin
      int c = 0;
      @(negedge clk);
      while (!smp_valid && c < 200) begin @(negedge clk); c++; end
      if (c >= 200) chk(0, "R2 step timeout", 0, 1);
      smp_ready = 1;
      @(negedge clk);
      smp_ready = 0;
    end
    repeat (20) @(negedge clk);
  endtask

  task automatic gap(output int g);
    int c = 0;
    @(negedge clk);
    while (!bclk_en && c < 4000) begin @(negedge clk); c++; end
    g = 0;
    do begin @(negedge clk); g++; end while (!bclk_en && g < 4000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, b2;
    logic [15:0] hl, hr;
    bit saw;
    int g;
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(8'h00, v); chk(v == 0, "R1 mode after reset", v, 0);
    rd(8'h20, v); chk(v == 0, "R1 status after reset", v, 0);
    rd(8'h24, v); chk(v == 0, "R1 enable after reset", v, 0);
    chk(!irq && !smp_valid, "R1 irq/valid after reset", {irq, smp_valid}, 0);
    saw = 0;
    repeat (30) begin @(negedge clk); if (mem_req) saw = 1; end
    chk(!saw, "R14 no request while stopped", saw, 0);

    for (int it = 0; it < 2; it++) begin
      for (int m = 0; m < 4; m++) begin
        bit s16 = m[0], mono = m[1];
        int thr = $urandom_range(1, 5);
        int len = (thr + 1) * 4;
        int fpb = len / ((s16 ? 2 : 1) * (mono ? 1 : 2));
        logic [31:0] base = $urandom & 32'h0FFF_FFFC;
        string tag;
        tag = s16 ? (mono ? "R8 16b mono" : "R7 16b stereo") : (mono ? "R10 8b mono" : "R9 8b stereo");
        start(base, thr, 32'h80 | {17'h0, mono, 13'h0, s16});
        run_stream(3 * fpb + 2, base, s16, mono, len, 0, tag);
        chk(!addr_bad, "R13 read address range", addr_bad, 0);
        drain();
      end
    end

    b2 = 32'h0123_4560;
    wr(8'h24, 32'h40);
    start(b2, 3, 32'h4080);
    repeat (20) @(negedge clk);
    rd(8'h20, v); chk(v == 0, "R2 no flag at start", v, 0);
    steps(6);
    rd(8'h20, v); chk(v == 0, "R2 no flag before half", v, 0);
    rd(8'h38, v); chk(v == 0, "R3 position first half", v, 0);
    chk(!irq, "R5 irq low before half", irq, 0);
    steps(1);
    rd(8'h20, v); chk(v == 32'h40, "R2 half flag", v, 32'h40);
    rd(8'h38, v); chk(v == 2, "R3 position second half", v, 2);
    chk(irq, "R5 irq on enabled half flag", irq, 1);
    wr(8'h20, 32'h40);
    rd(8'h20, v); chk(v == 0, "R4 clear half flag", v, 0);
    chk(!irq, "R5 irq low after clear", irq, 0);
    wr(8'h24, 32'h80);
    steps(8);
    rd(8'h20, v); chk(v == 32'h80, "R2 wrap flag", v, 32'h80);
    rd(8'h38, v); chk(v == 0, "R3 position after wrap", v, 0);
    chk(irq, "R5 irq on enabled wrap flag", irq, 1);
    wr(8'h20, 32'h40);
    rd(8'h20, v); chk(v == 32'h80, "R4 unwritten bit kept", v, 32'h80);

    hl = smp_left; hr = smp_right;
    saw = smp_valid;
    repeat (20) @(negedge clk);
    chk(saw && smp_valid && smp_left == hl && smp_right == hr, "R11 hold under stall",
        {smp_left, smp_right}, {hl, hr});
    rd(8'h20, v); chk(v == 32'h80, "R11 no advance under stall", v, 32'h80);

    steps(8);
    rd(8'h20, v); chk(v == 32'hC0, "R2 both flags", v, 32'hC0);
    wr(8'h18, 0);
    rd(8'h38, v); chk(v == 0, "R6 divider write resets position", v, 0);
    rd(8'h20, v); chk(v == 32'hC0, "R6 divider write keeps status", v, 32'hC0);
    wr(8'h00, 0);
    wr(8'h00, 32'h4080);
    rd(8'h20, v); chk(v == 0, "R6 run rising edge clears status", v, 0);
    run_stream(20, b2, 0, 1, 16, 1, "R6 restart from base");
    drain();

    wr(8'h18, 32'h0200);
    wr(8'h00, 32'h0200);
    gap(g); gap(g); chk(g == HI * 3, "R12 bit clock high reference", 32'(g), 32'(HI * 3));
    wr(8'h00, 0);
    gap(g); gap(g); chk(g == LO * 3, "R12 bit clock low reference", 32'(g), 32'(LO * 3));
    wr(8'h18, 0);
    gap(g); gap(g); chk(g == LO, "R12 bit clock divider zero", 32'(g), 32'(LO));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule